// File: doc/BRIEF.md
# Host Register Port with Mode/Sync/Command Setup Sequencer

This block is the processor-facing register port of a serial controller. It turns an active-low chip select, a control/data select line and active-low read and write strobes into four kinds of access: control-word writes, status reads, transmit-data writes and receive-data reads. Each access is recognized once, on the first clock cycle at which its strobe is seen asserted.

A control write does not have a fixed meaning. After reset, the sequencer waits for a mode byte. If that byte selects synchronous operation, the next control write is taken as the first sync character. A second sync character follows unless the mode byte asks for only one. After setup, each control write is passed on as a command. A command whose internal-reset bit is set sends the sequencer back to waiting for a mode byte. The latched mode fields, both sync characters, a setup-done flag and a one-cycle command strobe with its byte are presented to the serial logic around the block.

Data moves through plain one-cycle strobes with no back-pressure. `tx_load` carries a written byte and `rx_take` marks a receive-data read. The consumer must take the byte in the cycle in which the strobe is high. The data bus is not driven by the block itself. `dout_oe` tells an external pad buffer when to drive `dout`.

Top module: `mode_cmd_seq`

## Requirements
- R1: With `cs_n`=0 and `cd`=1, a read drives `dout` with `status_in` and sets `dout_oe`=1. A write is a control-word write.
- R2: With `cs_n`=0 and `cd`=0, a write raises `tx_load` for one cycle, in the cycle after the strobe is first seen, with `tx_byte` equal to the written byte. A read drives `dout` with `rx_data` and raises `rx_take` in the first cycle of the strobe.
- R3: While `cs_n`=1, `dout_oe` is 0 and no strobe causes any access.
- R4: After reset, `setup_done`=0 and the first control write is latched as the mode byte. The field layout is: bits 1:0 `mode_baud`, bits 3:2 `mode_clen`, bit 4 `mode_pen`, bit 5 `mode_even`, bits 7:6 `mode_stop`.
- R5: A mode byte with bits 1:0 not equal to 00 (asynchronous) raises `setup_done` at once.
- R6: A mode byte with bits 1:0 = 00 (synchronous) makes the next control write `sync1`. If mode bit 7 = 1, setup then ends. If mode bit 7 = 0, the next control write is `sync2` and setup ends after it.
- R7: When `setup_done`=1, each control write gives one cycle of `cmd_stb` with `cmd_byte` equal to the written byte. The mode fields do not change.
- R8: A command with bit 6 set clears `setup_done`, and the next control write is again taken as a mode byte.
- R9: When read and write strobes are low together, no access happens. `dout_oe` stays 0 and no latched state changes.
- R10: A strobe held low for many cycles counts as exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cs_n | input | 1 | Chip select, active low |
| cd | input | 1 | 1 selects control/status, 0 selects data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_oe | output | 1 | Drive enable for the external bus buffer |
| status_in | input | 8 | Status byte supplied by the serial logic |
| rx_data | input | 8 | Received byte supplied by the serial logic |
| rx_take | output | 1 | Pulse: the host read the received byte |
| tx_load | output | 1 | Pulse: a transmit byte was written |
| tx_byte | output | 8 | Transmit byte, valid with `tx_load` |
| mode_baud | output | 2 | Baud-factor field, 00 means synchronous |
| mode_clen | output | 2 | Character-length field |
| mode_pen | output | 1 | Parity enable |
| mode_even | output | 1 | Even parity select |
| mode_stop | output | 2 | Stop-length field, or sync options in synchronous mode |
| sync1 | output | 8 | First sync character |
| sync2 | output | 8 | Second sync character |
| setup_done | output | 1 | Setup finished; control writes are commands |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Last command byte |

## Verification
The assertions assume that the host strobes are synchronous to `clk` and that `din`, `cd` and `cs_n` are steady while a strobe is low. They also assume that a strobe goes high for at least one cycle between accesses. The bench changes every input on the falling clock edge, keeps address and data fixed for the whole strobe and releases the strobe before it starts the next access. The overlapping-strobe and held-strobe cases are driven on purpose, to show that the rules above cover them.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [1:0] {
    ST_MODE  = 2'd0,
    ST_SYNC1 = 2'd1,
    ST_SYNC2 = 2'd2,
    ST_CMD   = 2'd3
  } seq_state_t;

  // packed MSB first so a raw mode byte casts straight onto the fields
  typedef struct packed {
    logic [1:0] stop;
    logic       even;
    logic       pen;
    logic [1:0] clen;
    logic [1:0] baud;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/mcs_bus_decode.sv
module mcs_bus_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic cd,
  input  logic rd_n,
  input  logic wr_n,
  output logic wr_ctrl,
  output logic wr_data,
  output logic rd_stat,
  output logic rd_data,
  output logic rd_active
);
  logic wr_act, rd_act, wr_q, rd_q, wr_evt, rd_evt;

  // overlapping strobes are treated as no access at all
  assign wr_act    = !cs_n && !wr_n && rd_n;
  assign rd_act    = !cs_n && !rd_n && wr_n;
  assign rd_active = rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end
  end

  assign wr_evt  = wr_act && !wr_q;
  assign rd_evt  = rd_act && !rd_q;
  assign wr_ctrl = wr_evt && cd;
  assign wr_data = wr_evt && !cd;
  assign rd_stat = rd_evt && cd;
  assign rd_data = rd_evt && !cd;
endmodule

// File: rtl/mcs_setup_fsm.sv
module mcs_setup_fsm
  import mcs_pkg::*;
#(
  parameter int DW         = 8,
  parameter int IRST_BIT   = 6,
  parameter int SINGLE_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] din,
  output mode_t         mode,
  output logic [DW-1:0] sync1,
  output logic [DW-1:0] sync2,
  output logic          setup_done,
  output logic          cmd_stb,
  output logic [DW-1:0] cmd_byte
);
  seq_state_t state;
  mode_t      mode_in;

  assign mode_in    = mode_t'(din[MODE_W-1:0]);
  assign setup_done = (state == ST_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_MODE;
      mode     <= '0;
      sync1    <= '0;
      sync2    <= '0;
      cmd_stb  <= 1'b0;
      cmd_byte <= '0;
    end else begin
      cmd_stb <= 1'b0;
      if (wr_ctrl) begin
        unique case (state)
          ST_MODE: begin
            mode  <= mode_in;
            state <= (mode_in.baud == 2'b00) ? ST_SYNC1 : ST_CMD;
          end
          ST_SYNC1: begin
            sync1 <= din;
            state <= mode[SINGLE_BIT] ? ST_CMD : ST_SYNC2;
          end
          ST_SYNC2: begin
            sync2 <= din;
            state <= ST_CMD;
          end
          ST_CMD: begin
            cmd_stb  <= 1'b1;
            cmd_byte <= din;
            if (din[IRST_BIT]) state <= ST_MODE;
          end
          default: state <= ST_MODE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mode_cmd_seq.sv
module mode_cmd_seq
  import mcs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cd,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  input  logic [DW-1:0] status_in,
  input  logic [DW-1:0] rx_data,
  output logic          rx_take,
  output logic          tx_load,
  output logic [DW-1:0] tx_byte,
  output logic [1:0]    mode_baud,
  output logic [1:0]    mode_clen,
  output logic          mode_pen,
  output logic          mode_even,
  output logic [1:0]    mode_stop,
  output logic [DW-1:0] sync1,
  output logic [DW-1:0] sync2,
  output logic          setup_done,
  output logic          cmd_stb,
  output logic [DW-1:0] cmd_byte
);
  logic  wr_ctrl, wr_data, rd_stat, rd_data, rd_active;
  mode_t mode;

  mcs_bus_decode u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
    .wr_ctrl(wr_ctrl), .wr_data(wr_data), .rd_stat(rd_stat), .rd_data(rd_data),
    .rd_active(rd_active)
  );

  mcs_setup_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .din(din),
    .mode(mode), .sync1(sync1), .sync2(sync2), .setup_done(setup_done),
    .cmd_stb(cmd_stb), .cmd_byte(cmd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_load <= 1'b0;
      tx_byte <= '0;
    end else begin
      tx_load <= wr_data;
      if (wr_data) tx_byte <= din;
    end
  end

  assign dout_oe   = rd_active;
  assign dout      = cd ? status_in : rx_data;
  assign rx_take   = rd_data;
  assign mode_baud = mode.baud;
  assign mode_clen = mode.clen;
  assign mode_pen  = mode.pen;
  assign mode_even = mode.even;
  assign mode_stop = mode.stop;

  logic unused_ok;
  assign unused_ok = rd_stat;
endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       cd,
  input logic       rd_n,
  input logic       wr_n,
  input logic       dout_oe,
  input logic       tx_load,
  input logic       cmd_stb,
  input logic       setup_done,
  input logic [1:0] mode_baud,
  input logic [1:0] mode_clen,
  input logic       mode_pen,
  input logic       mode_even,
  input logic [1:0] mode_stop
);
  // R3: no bus drive without chip select and a clean read
  a_r3_oe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> (!cs_n && !rd_n && wr_n));

  // R9: overlapping strobes never drive the bus
  a_r9_overlap_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |-> !dout_oe);

  // R2: a transmit load follows a data write
  a_r2_tx_after_data_wr: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> $past(!cs_n && !wr_n && rd_n && !cd));

  // R7: commands only come from the post-setup state
  a_r7_cmd_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(setup_done));

  // R10: a strobe yields at most one command pulse in a row
  a_r10_single_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R7: mode fields frozen while commands are accepted
  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_done && $past(setup_done)) |->
      ($stable(mode_baud) && $stable(mode_clen) && $stable(mode_pen) &&
       $stable(mode_even) && $stable(mode_stop)));
endmodule

bind mode_cmd_seq mcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cd(cd), .rd_n(rd_n), .wr_n(wr_n),
  .dout_oe(dout_oe), .tx_load(tx_load), .cmd_stb(cmd_stb),
  .setup_done(setup_done), .mode_baud(mode_baud), .mode_clen(mode_clen),
  .mode_pen(mode_pen), .mode_even(mode_even), .mode_stop(mode_stop)
);

// File: tb/mode_cmd_seq_tb.sv
module mode_cmd_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, cd = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] din = '0, status_in = 8'hA5, rx_data = 8'h3C;
  logic [7:0] dout, tx_byte, sync1, sync2, cmd_byte;
  logic       dout_oe, rx_take, tx_load, setup_done, cmd_stb;
  logic [1:0] mode_baud, mode_clen, mode_stop;
  logic       mode_pen, mode_even;

  int checks = 0, fails = 0;
  logic       s_cmd, s_tx;
  logic [7:0] s_cmd_b, s_tx_b;

  always #10 clk = ~clk;

  mode_cmd_seq u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mode_now();
    return {mode_stop, mode_even, mode_pen, mode_clen, mode_baud};
  endfunction

  task automatic wr(input logic c, input logic [7:0] b);
    @(negedge clk); cs_n = 0; cd = c; din = b; wr_n = 0;
    @(negedge clk);
    s_cmd = cmd_stb; s_cmd_b = cmd_byte; s_tx = tx_load; s_tx_b = tx_byte;
    wr_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R4 reset setup_done", setup_done, 0);
    chk("R4 reset mode", mode_now(), 0);
    chk("R3 reset oe", dout_oe, 0);
  endtask

  task automatic t_async();
    do_reset();
    wr(1, 8'b1101_1110);
    chk("R4 mode byte", mode_now(), 8'hDE);
    chk("R5 async done", setup_done, 1);
  endtask

  task automatic t_sync_two();
    do_reset();
    wr(1, 8'b0001_1100);
    chk("R6 after mode", setup_done, 0);
    wr(1, 8'h16);
    chk("R6 sync1", sync1, 8'h16);
    chk("R6 still setup", setup_done, 0);
    wr(1, 8'h2B);
    chk("R6 sync2", sync2, 8'h2B);
    chk("R6 done", setup_done, 1);
  endtask

  task automatic t_sync_one();
    do_reset();
    wr(1, 8'b1000_0100);
    wr(1, 8'h55);
    chk("R6 single sync1", sync1, 8'h55);
    chk("R6 single done", setup_done, 1);
    chk("R6 sync2 untouched", sync2, 0);
  endtask

  task automatic t_cmd();
    do_reset();
    wr(1, 8'h4E);
    wr(1, 8'h37);
    chk("R7 cmd_stb", s_cmd, 1);
    chk("R7 cmd_byte", s_cmd_b, 8'h37);
    chk("R7 mode kept", mode_now(), 8'h4E);
    wr(1, 8'h40);
    chk("R8 irst stb", s_cmd, 1);
    chk("R8 irst back", setup_done, 0);
    wr(1, 8'h07);
    chk("R8 new mode", mode_now(), 8'h07);
    chk("R8 done again", setup_done, 1);
  endtask

  task automatic t_data();
    wr(0, 8'h9A);
    chk("R2 tx_load", s_tx, 1);
    chk("R2 tx_byte", s_tx_b, 8'h9A);
    chk("R2 no cmd", s_cmd, 0);
    @(negedge clk); cs_n = 0; cd = 0; rd_n = 0; #1;
    chk("R2 rx read", dout, 8'h3C);
    chk("R2 rx_take", rx_take, 1);
    chk("R2 oe", dout_oe, 1);
    @(negedge clk); rd_n = 1; cs_n = 1;
    @(negedge clk); cs_n = 0; cd = 1; rd_n = 0; #1;
    chk("R1 status", dout, 8'hA5);
    chk("R1 oe", dout_oe, 1);
    chk("R1 no rx_take", rx_take, 0);
    @(negedge clk); rd_n = 1; cs_n = 1;
  endtask

  task automatic t_cs_high();
    do_reset();
    @(negedge clk); cs_n = 1; cd = 1; din = 8'h4E; wr_n = 0;
    @(negedge clk); @(negedge clk); wr_n = 1; rd_n = 0; #1;
    chk("R3 oe off", dout_oe, 0);
    chk("R3 no mode", mode_now(), 0);
    chk("R3 no setup", setup_done, 0);
    @(negedge clk); rd_n = 1;
  endtask

  task automatic t_overlap();
    do_reset();
    @(negedge clk); cs_n = 0; cd = 1; din = 8'h4E; wr_n = 0; rd_n = 0;
    @(negedge clk); #1;
    chk("R9 oe off", dout_oe, 0);
    @(negedge clk); rd_n = 1; wr_n = 1; cs_n = 1;
    @(negedge clk);
    chk("R9 no mode", mode_now(), 0);
    chk("R9 no setup", setup_done, 0);
  endtask

  task automatic t_long();
    int n = 0;
    do_reset();
    wr(1, 8'h4E);
    @(negedge clk); cs_n = 0; cd = 1; din = 8'h15; wr_n = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (cmd_stb) n++; end
    wr_n = 1; cs_n = 1;
    @(negedge clk); if (cmd_stb) n++;
    chk("R10 one cmd", n, 1);
    chk("R10 cmd_byte", cmd_byte, 8'h15);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_async(); t_sync_two(); t_sync_one();
        t_cmd(); t_data(); t_cs_high(); t_overlap(); t_long();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule